// File: doc/BRIEF.md
# Level-Interrupt GPIO Controller

This block is a general-purpose I/O controller for up to 32 lines. Each line can be set as an input or as an output. Software reaches the block over a small synchronous register bus. Through it, software reads the pin levels, drives output values and picks, for each line, whether a high or a low level counts as an interrupt.

Every input goes through a two-flop synchroniser. The synchronised value feeds both the data readback and the level detector. While a line sits at its chosen level, its bit in a sticky status word is set. Software clears one line at a time by writing a word in which only that line's bit is zero.

A second register window, picked by a window-select input, holds a read-only pending word and a mask word. The pending word mirrors the status bits. The mask word comes out of reset with every line masked. The single interrupt output is raised when any pending bit has its mask bit clear.

Top module: `lvl_gpio`

## Requirements
- R1: After reset the direction word is 0 (all inputs) and the drive word is 0. The level-select word reads 0xFFFFFFFF, the mask word reads 0xFFFFFFFF, the status word reads 0 and `irq` is 0.
- R2: In the GPIO window (`bus_win`=0), a write to offset 0x04 sets the direction word and a write to offset 0x08 sets the drive word. A direction bit of 1 makes the line an output: `pin_oe` equals the direction word and `pin_out` equals the drive word. Reading offset 0x08 returns the drive bit for output lines and the synchronised pin for input lines.
- R3: A change on `pin_in` passes through two flops before it is used. The status bit it produces is set on the third rising edge after the change, so `irq` for an unmasked line rises after that third edge and not before.
- R4: The level-select word is at GPIO offset 0x0C. A bit of 1 makes its line active when the synchronised input is high, and a bit of 0 makes it active when the input is low.
- R5: The status word is at GPIO offset 0x10. A status bit is set on every cycle in which its line is at the active level, and it stays set after the condition goes away.
- R6: A write to the status word clears each bit written as 0 and leaves each bit written as 1 unchanged. A cleared bit whose line is still at the active level reads 1 again afterwards.
- R7: In the interrupt window (`bus_win`=1), offset 0x00 reads the status bits as the pending word. Writes to that offset change nothing.
- R8: The mask word is at interrupt-window offset 0x08. A mask bit of 1 blocks its line. `irq` is 1 exactly when some pending bit has its mask bit at 0, and it follows a mask write after one rising edge.
- R9: Undefined offsets (GPIO 0x00 and 0x14, interrupt 0x04) read as 0, and writes to them change no register.
- R10: A read (`bus_vld`=1, `bus_we`=0) returns its data on `bus_rdata` after the next rising edge. After any cycle without a read, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | Window select: 0 = GPIO, 1 = interrupt |
| bus_addr | input | AW (5) | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pin_in | input | N (32) | Pin levels from the pads |
| pin_out | output | N (32) | Drive values to the pads |
| pin_oe | output | N (32) | Output enables to the pads (1 = drive) |
| irq | output | 1 | Combined interrupt |

## Verification
Read data is due one rising edge after the read strobe. The bench drives the strobe at a falling edge and samples `bus_rdata` at the next falling edge. A pin change reaches the status word on the third rising edge, so the timing test samples `irq` at the first, second and third falling edges after the change: it expects 0, 0 and 1. A mask or status write acts after one rising edge, and every other check samples only after several idle cycles, so the pipeline has settled.

// File: rtl/lvl_gpio.sv
module lvl_gpio #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_vld,
  input  logic          bus_we,
  input  logic          bus_win,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_DIR  = AW'(4);
  localparam logic [AW-1:0] A_DATA = AW'(8);
  localparam logic [AW-1:0] A_LVL  = AW'(12);
  localparam logic [AW-1:0] A_STAT = AW'(16);
  localparam logic [AW-1:0] A_PEND = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(8);

  logic [N-1:0] s1, s2, dir_q, dout_q, lvl_q, stat_q, mask_q;
  logic [31:0]  rmux;

  function automatic logic [31:0] ext(input logic [N-1:0] x);
    ext = '0;
    ext[N-1:0] = x;
  endfunction

  wire wr = bus_vld &  bus_we;
  wire rd = bus_vld & ~bus_we;

  wire sel_dir  = ~bus_win & (bus_addr == A_DIR);
  wire sel_data = ~bus_win & (bus_addr == A_DATA);
  wire sel_lvl  = ~bus_win & (bus_addr == A_LVL);
  wire sel_stat = ~bus_win & (bus_addr == A_STAT);
  wire sel_pend =  bus_win & (bus_addr == A_PEND);
  wire sel_mask =  bus_win & (bus_addr == A_MASK);

  wire [N-1:0] hit  = ~(s2 ^ lvl_q);
  wire [N-1:0] keep = (wr & sel_stat) ? bus_wdata[N-1:0] : {N{1'b1}};
  wire [N-1:0] din  = (dir_q & dout_q) | (~dir_q & s2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      lvl_q  <= '1;
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      s1     <= pin_in;
      s2     <= s1;
      stat_q <= (stat_q & keep) | hit;
      if (wr && sel_dir)  dir_q  <= bus_wdata[N-1:0];
      if (wr && sel_data) dout_q <= bus_wdata[N-1:0];
      if (wr && sel_lvl)  lvl_q  <= bus_wdata[N-1:0];
      if (wr && sel_mask) mask_q <= bus_wdata[N-1:0];
    end
  end

  assign rmux = ({32{sel_dir}}  & ext(dir_q))
              | ({32{sel_data}} & ext(din))
              | ({32{sel_lvl}}  & ext(lvl_q))
              | ({32{sel_stat | sel_pend}} & ext(stat_q))
              | ({32{sel_mask}} & ext(mask_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd ? rmux : 32'd0;
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq     = |(stat_q & ~mask_q);
endmodule

// File: rtl/lvl_gpio_chk.sv
module lvl_gpio_chk #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_vld,
  input logic          bus_we,
  input logic          bus_win,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_rdata,
  input logic [N-1:0]  pin_oe,
  input logic          irq,
  input logic [N-1:0]  stat_q,
  input logic [N-1:0]  mask_q
);
  wire wr_stat = bus_vld && bus_we && !bus_win && bus_addr == AW'(16);
  wire wr_dir  = bus_vld && bus_we && !bus_win && bus_addr == AW'(4);
  wire wr_mask = bus_vld && bus_we &&  bus_win && bus_addr == AW'(8);
  wire wr_hole = bus_vld && bus_we && ((!bus_win && (bus_addr == AW'(0) || bus_addr == AW'(20)))
                                    || ( bus_win &&  bus_addr == AW'(4)));

  // R5
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  // R9
  hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hole |=> ($stable(mask_q) && $stable(pin_oe)));

  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && !bus_we) |=> (bus_rdata == 32'd0));

  // R8
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
endmodule

bind lvl_gpio lvl_gpio_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we),
  .bus_win(bus_win), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .irq(irq), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/lvl_gpio_test.sv
`timescale 1ns/1ps
module lvl_gpio_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_vld = 0, bus_we = 0, bus_win = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = 0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  lvl_gpio uut (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we),
    .bus_win(bus_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_vld = 0; pin_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic win, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_vld = 1; bus_we = 1; bus_win = win; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 0; bus_we = 0;
  endtask

  task automatic rd(input logic win, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_vld = 1; bus_we = 0; bus_win = win; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_vld = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(0, 5'h04, v); chk("R1 dir", v, 32'h0);
    rd(0, 5'h08, v); chk("R1 data", v, 32'h0);
    rd(0, 5'h0C, v); chk("R1 level", v, 32'hFFFFFFFF);
    rd(0, 5'h10, v); chk("R1 status", v, 32'h0);
    rd(1, 5'h08, v); chk("R1 mask", v, 32'hFFFFFFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
  endtask

  task automatic t_direction();
    logic [31:0] v;
    do_reset();
    wr(0, 5'h04, 32'h0000FFFF);
    wr(0, 5'h08, 32'h12345678);
    pin_in = 32'hA5A5FFFF;
    idle(4);
    chk("R2 pin_oe", pin_oe, 32'h0000FFFF);
    chk("R2 pin_out", pin_out, 32'h12345678);
    rd(0, 5'h08, v); chk("R2 data mix", v, 32'hA5A55678);
  endtask

  task automatic t_sync();
    do_reset();
    wr(1, 5'h08, 32'hFFFFFFFE);
    pin_in[0] = 1'b1;
    @(negedge clk); chk("R3 irq edge1", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R3 irq edge2", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R3 irq edge3", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    wr(0, 5'h0C, 32'h0000000F);
    pin_in = 32'h00000005;
    idle(4);
    rd(0, 5'h10, v); chk("R4 polarity", v, 32'hFFFFFFF5);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    do_reset();
    pin_in = 32'h00000210; idle(4);
    pin_in = 32'h0; idle(4);
    rd(0, 5'h10, v); chk("R5 sticky", v, 32'h00000210);
    wr(0, 5'h10, 32'hFFFFFFEF); idle(1);
    rd(0, 5'h10, v); chk("R6 single clear", v, 32'h00000200);
    pin_in = 32'h00000100; idle(4);
    wr(0, 5'h10, 32'hFFFFFEFF); idle(1);
    rd(0, 5'h10, v); chk("R6 reassert", v, 32'h00000300);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    do_reset();
    pin_in = 32'h8; idle(4);
    pin_in = 32'h0; idle(4);
    rd(1, 5'h00, v); chk("R7 pending", v, 32'h8);
    chk("R8 masked irq", {31'b0, irq}, 32'h0);
    wr(1, 5'h08, 32'hFFFFFFFE);
    chk("R8 other unmasked", {31'b0, irq}, 32'h0);
    wr(1, 5'h08, 32'hFFFFFFF7);
    chk("R8 unmasked irq", {31'b0, irq}, 32'h1);
    wr(1, 5'h00, 32'h0); idle(1);
    rd(1, 5'h00, v); chk("R7 pending ro", v, 32'h8);
    wr(1, 5'h08, 32'hFFFFFFFF);
    chk("R8 remasked", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_undef();
    logic [31:0] v;
    do_reset();
    wr(0, 5'h00, 32'hFFFFFFFF);
    wr(0, 5'h14, 32'h0);
    wr(1, 5'h04, 32'h0);
    idle(1);
    rd(0, 5'h00, v); chk("R9 gpio hole0", v, 32'h0);
    rd(0, 5'h14, v); chk("R9 gpio hole14", v, 32'h0);
    rd(1, 5'h04, v); chk("R9 intc hole4", v, 32'h0);
    rd(0, 5'h04, v); chk("R9 dir kept", v, 32'h0);
    rd(0, 5'h0C, v); chk("R9 level kept", v, 32'hFFFFFFFF);
    rd(1, 5'h08, v); chk("R9 mask kept", v, 32'hFFFFFFFF);
    chk("R9 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rdata();
    logic [31:0] v;
    do_reset();
    rd(1, 5'h08, v); chk("R10 read latency", v, 32'hFFFFFFFF);
    @(negedge clk); chk("R10 idle zero", bus_rdata, 32'h0);
  endtask

  initial begin
    t_reset();
    t_direction();
    t_sync();
    t_level();
    t_clear();
    t_mask();
    t_undef();
    t_rdata();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule